// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block sequences the low-power modes of a small 8-bit microcontroller core. Software asks for a mode by writing two request bits, one for Idle and one for Power-Down, through a one-cycle write strobe. The controller then gates the CPU clock and the peripheral-timer clock, and in Power-Down it also switches the oscillator off. It decides which events may wake the core and, on a wake from Power-Down, times the oscillator restart before it lets the CPU run again. It also produces the internal phase clock by dividing the input clock by two, and a strobe that tells the register file to load its reset values.

The controller is a five-state machine. `RUN` is normal operation. `IDLE` stops the CPU clock and keeps the oscillator running. `PDOWN` stops everything. `OSC_WAIT` turns the oscillator back on while a qualified wake pin is held low, and counts the start-up time. `HOLD_LOW` keeps the CPU clock gated until the wake pin is released. The transitions are:
- *enter_idle*: `RUN`→`IDLE`
- *enter_pdown*: `RUN`→`PDOWN`
- *idle_wake*: `IDLE`→`RUN`
- *pin_low*: `PDOWN`→`OSC_WAIT`
- *early_release*: `OSC_WAIT`→`PDOWN`
- *stable*: `OSC_WAIT`→`HOLD_LOW`
- *pin_high*: `HOLD_LOW`→`RUN`

A hardware reset sends any state to `RUN`. An exit through an interrupt keeps the register contents, so the restore strobe is not raised. The stimulus pins are assumed to be already synchronous to `clk_in`.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is in `RUN`. In `RUN`, `cpu_clk_en`, `tmr_clk_en` and `osc_en` are 1, and `idle_flag` and `pdown_flag` are 0.
- R2: `phase_clk` inverts on every rising edge of `clk_in` at which `osc_en` is 1, and holds its value while `osc_en` is 0.
- R3: In `RUN`, a write (`mode_wr`=1) with `mode_idle`=1 and `mode_pdown`=0 takes effect one cycle later. From then on `cpu_clk_en` is 0, `osc_en` is 1 and `idle_flag` is 1.
- R4: In `IDLE`, `tmr_clk_en` equals `tmr_idle_run`.
- R5: `IDLE` returns to `RUN` one cycle after `irq_other` is 1, or after any external pin with `ext_en`=1 is low. This applies to both trigger types. On return, `idle_flag` clears.
- R6: In `RUN`, a write with `mode_pdown`=1 enters `PDOWN` one cycle later, even if `mode_idle` is also 1. In `PDOWN`, `cpu_clk_en`, `tmr_clk_en` and `osc_en` are 0 and `pdown_flag` is 1.
- R7: In `PDOWN`, the following leave `osc_en` at 0 and `pdown_flag` at 1:
  - `irq_other`
  - an external pin that is disabled (`ext_en`=0)
  - an external pin set to edge-trigger (`ext_edge`=1)
- R8: In `PDOWN`, a pin low with `ext_en`=1 and `ext_edge`=0 (level type) raises `osc_en` one cycle later, with `cpu_clk_en` still 0.
- R9: If no qualified pin is low on any of the `STAB_CYCLES`+1 edges after wake-up begins, the block goes back to `PDOWN` and `osc_en` returns to 0. This includes a pin held low on only `STAB_CYCLES` edges.
- R10: The exit from Power-Down completes only when both of these hold:
  - a qualified pin has been held low on `STAB_CYCLES`+1 consecutive edges;
  - that pin has then been released.
  `cpu_clk_en` stays 0 while the pin is low, and becomes 1 one cycle after the release. At the same point `pdown_flag` clears and `sfr_init` stays 0.
- R11: `sfr_init` is 1 while `rst_n` is low and falls at the first rising edge after release. A reset taken in `PDOWN` returns the block to `RUN`.
- R12: A write on `mode_wr` outside `RUN` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock (oscillator output) |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mode_wr | input | 1 | One-cycle write strobe for the request bits |
| mode_idle | input | 1 | Idle request bit |
| mode_pdown | input | 1 | Power-Down request bit |
| tmr_idle_run | input | 1 | 1: timer keeps counting in Idle |
| ext_pin_n | input | N_EXT | External interrupt pins, active low |
| ext_en | input | N_EXT | Per-pin interrupt enable |
| ext_edge | input | N_EXT | Per-pin trigger type, 1 = edge, 0 = level |
| irq_other | input | 1 | Any other enabled interrupt pending |
| phase_clk | output | 1 | Divide-by-two internal phase clock |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| tmr_clk_en | output | 1 | Peripheral timer clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_init | output | 1 | Register-file reset-value strobe |
| idle_flag | output | 1 | Idle request bit readback |
| pdown_flag | output | 1 | Power-Down request bit readback |

## Verification
Every output is decoded from the state register, so each result becomes visible one rising edge after the stimulus that causes it. The bench therefore drives inputs on the falling edge and checks them at the next falling edge.

The start-up wait is checked by counting edges with the wake pin held low:
- a pin held low for `STAB_CYCLES` edges must fall back to Power-Down;
- a pin held low for `STAB_CYCLES`+1 edges must reach `HOLD_LOW`;
- the CPU clock must then open exactly one edge after the pin is released.

`sfr_init` is checked during reset and at the first falling edge after release.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_PDOWN    = 3'd2,
        ST_OSC_WAIT = 3'd3,
        ST_HOLD_LOW = 3'd4
    } pwr_state_e;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
    parameter int N_EXT = 2
) (
    input  logic [N_EXT-1:0] ext_pin_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_edge,
    input  logic             irq_other,
    output logic             pd_wake,
    output logic             idle_wake
);
    logic [N_EXT-1:0] pin_lvl_ok;
    logic [N_EXT-1:0] pin_any_ok;

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        // level-type, enabled, held low: the only Power-Down wake source (R8)
        assign pin_lvl_ok[i] = ~ext_pin_n[i] & ext_en[i] & ~ext_edge[i];
        // any enabled pin wakes Idle regardless of trigger type (R5)
        assign pin_any_ok[i] = ~ext_pin_n[i] & ext_en[i];
    end

    assign pd_wake   = |pin_lvl_ok;
    assign idle_wake = (|pin_any_ok) | irq_other;
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // counter never passes the programmed start-up limit (R9)
    p_cnt_bound_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int STAB_CYCLES = 1024,
    parameter int N_EXT       = 2
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_idle,
    input  logic             mode_pdown,
    input  logic             tmr_idle_run,
    input  logic [N_EXT-1:0] ext_pin_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_edge,
    input  logic             irq_other,
    output logic             phase_clk,
    output logic             cpu_clk_en,
    output logic             tmr_clk_en,
    output logic             osc_en,
    output logic             sfr_init,
    output logic             idle_flag,
    output logic             pdown_flag
);
    pwr_state_e state_q, state_d;
    logic pd_wake, idle_wake, stab_done, stab_run;
    logic chk_armed;

    pwr_wake_qual #(.N_EXT(N_EXT)) u_qual (
        .ext_pin_n (ext_pin_n),
        .ext_en    (ext_en),
        .ext_edge  (ext_edge),
        .irq_other (irq_other),
        .pd_wake   (pd_wake),
        .idle_wake (idle_wake)
    );

    assign stab_run = (state_q == ST_OSC_WAIT);

    pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .run    (stab_run),
        .done   (stab_done)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (mode_wr && mode_pdown)     state_d = ST_PDOWN;
                else if (mode_wr && mode_idle) state_d = ST_IDLE;
            end
            ST_IDLE:     if (idle_wake) state_d = ST_RUN;
            ST_PDOWN:    if (pd_wake)   state_d = ST_OSC_WAIT;
            ST_OSC_WAIT: begin
                if (!pd_wake)       state_d = ST_PDOWN;
                else if (stab_done) state_d = ST_HOLD_LOW;
            end
            ST_HOLD_LOW: if (!pd_wake) state_d = ST_RUN;
            default:                   state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        cpu_clk_en = 1'b0;
        tmr_clk_en = 1'b0;
        osc_en     = 1'b1;
        idle_flag  = 1'b0;
        pdown_flag = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                tmr_clk_en = 1'b1;
            end
            ST_IDLE: begin
                tmr_clk_en = tmr_idle_run;
                idle_flag  = 1'b1;
            end
            ST_PDOWN: begin
                osc_en     = 1'b0;
                pdown_flag = 1'b1;
            end
            ST_OSC_WAIT, ST_HOLD_LOW: pdown_flag = 1'b1;
            default: begin
                cpu_clk_en = 1'b1;
                tmr_clk_en = 1'b1;
            end
        endcase
    end

    // divide-by-two phase clock, frozen with the oscillator
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n)      phase_clk <= 1'b0;
        else if (osc_en) phase_clk <= ~phase_clk;
    end

    // register-file reset strobe: only a hardware reset raises it
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) sfr_init <= 1'b1;
        else        sfr_init <= 1'b0;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    p_phase_toggle_r2: assert property (@(posedge clk_in) disable iff (!rst_n || !chk_armed)
        osc_en |=> (phase_clk != $past(phase_clk)));
    p_phase_hold_r2: assert property (@(posedge clk_in) disable iff (!rst_n || !chk_armed)
        !osc_en |=> $stable(phase_clk));
    p_osc_gates_cpu_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);
    p_pd_priority_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == ST_RUN && mode_wr && mode_pdown) |=> (pdown_flag && !osc_en));
    p_pd_no_direct_run_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == ST_PDOWN) |=> !cpu_clk_en);
    p_early_release_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == ST_OSC_WAIT && !pd_wake) |=> (state_q == ST_PDOWN));
    p_release_opens_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == ST_HOLD_LOW && !pd_wake) |=> (cpu_clk_en && !pdown_flag));
    p_no_restore_on_wake_r10: assert property (@(posedge clk_in) disable iff (!rst_n || !chk_armed)
        !sfr_init);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
    localparam int N = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0, mode_idle = 1'b0, mode_pdown = 1'b0, tmr_idle_run = 1'b0;
    logic [1:0] ext_pin_n = 2'b11, ext_en = 2'b00, ext_edge = 2'b00;
    logic irq_other = 1'b0;
    logic phase_clk, cpu_clk_en, tmr_clk_en, osc_en, sfr_init, idle_flag, pdown_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.STAB_CYCLES(N), .N_EXT(2)) uut (
        .clk_in(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_idle(mode_idle),
        .mode_pdown(mode_pdown), .tmr_idle_run(tmr_idle_run), .ext_pin_n(ext_pin_n),
        .ext_en(ext_en), .ext_edge(ext_edge), .irq_other(irq_other),
        .phase_clk(phase_clk), .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en),
        .osc_en(osc_en), .sfr_init(sfr_init), .idle_flag(idle_flag), .pdown_flag(pdown_flag)
    );

    // vector: {idle, pdown, tmr_cfg, exp_cpu, exp_tmr, exp_osc, exp_idle, exp_pd}
    localparam logic [7:0] VEC [5] = '{
        8'b100_00110,   // R3 idle, timer paused
        8'b101_01110,   // R4 idle, timer running
        8'b010_00001,   // R6 power-down
        8'b111_00001,   // R6 both bits: power-down wins
        8'b001_11100    // no request bit: stays in run
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode_wr = 1'b0; irq_other = 1'b0;
        ext_pin_n = 2'b11; ext_en = 2'b00; ext_edge = 2'b00;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic write_mode(logic idl, logic pd);
        mode_idle = idl; mode_pdown = pd; mode_wr = 1'b1;
        tick();
        mode_wr = 1'b0; mode_idle = 1'b0; mode_pdown = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic p0;
        // R1 / R11 reset state
        rst_n = 1'b0;
        tick();
        check("R11 sfr_init in reset", sfr_init, 1'b1);
        check("R1 osc in reset", osc_en, 1'b1);
        rst_n = 1'b1;
        tick();
        check("R11 sfr_init after release", sfr_init, 1'b0);
        check("R1 cpu_clk_en", cpu_clk_en, 1'b1);
        check("R1 tmr_clk_en", tmr_clk_en, 1'b1);
        check("R1 flags", idle_flag | pdown_flag, 1'b0);

        // table walk: R3 R4 R6
        for (int v = 0; v < 5; v++) begin
            do_reset();
            tmr_idle_run = VEC[v][5];
            write_mode(VEC[v][7], VEC[v][6]);
            check("R3/R4/R6 cpu", cpu_clk_en, VEC[v][4]);
            check("R3/R4/R6 tmr", tmr_clk_en, VEC[v][3]);
            check("R3/R4/R6 osc", osc_en, VEC[v][2]);
            check("R3/R4/R6 idle_flag", idle_flag, VEC[v][1]);
            check("R3/R4/R6 pdown_flag", pdown_flag, VEC[v][0]);
        end
        tmr_idle_run = 1'b0;

        // R2 phase toggles in run, freezes in power-down
        do_reset();
        p0 = phase_clk; tick();
        check("R2 toggle in run", phase_clk, ~p0);
        write_mode(1'b0, 1'b1);
        p0 = phase_clk; tick(); tick();
        check("R2 frozen in power-down", phase_clk, p0);

        // R12 write outside RUN ignored, R5 idle wake by other irq
        do_reset();
        write_mode(1'b1, 1'b0);
        write_mode(1'b0, 1'b1);
        check("R12 pdown write in idle", pdown_flag, 1'b0);
        check("R12 still idle", idle_flag, 1'b1);
        irq_other = 1'b1; tick(); irq_other = 1'b0;
        check("R5 wake by irq_other", cpu_clk_en, 1'b1);
        check("R5 idle_flag cleared", idle_flag, 1'b0);

        // R5 idle wake by enabled edge-type pin
        write_mode(1'b1, 1'b0);
        ext_en = 2'b01; ext_edge = 2'b01; ext_pin_n = 2'b10;
        tick();
        check("R5 wake by edge pin", cpu_clk_en, 1'b1);
        ext_pin_n = 2'b11; ext_en = 2'b00; ext_edge = 2'b00;
        tick();

        // R7 ignored sources in power-down
        write_mode(1'b0, 1'b1);
        irq_other = 1'b1;
        ext_en = 2'b01; ext_edge = 2'b01; ext_pin_n = 2'b00;  // pin0 edge, pin1 disabled
        tick(); tick(); tick();
        check("R7 osc stays off", osc_en, 1'b0);
        check("R7 still power-down", pdown_flag, 1'b1);
        irq_other = 1'b0; ext_pin_n = 2'b11; ext_en = 2'b00; ext_edge = 2'b00;
        tick();

        // R8 qualified pin starts oscillator; R9 release after N edges
        ext_en = 2'b10; ext_pin_n = 2'b01;
        tick();
        check("R8 osc on", osc_en, 1'b1);
        check("R8 cpu gated", cpu_clk_en, 1'b0);
        for (int i = 1; i < N; i++) tick();
        ext_pin_n = 2'b11;
        tick();
        check("R9 back to power-down osc", osc_en, 1'b0);
        check("R9 pdown_flag", pdown_flag, 1'b1);

        // R10 full exit after N+1 edges and release
        ext_pin_n = 2'b01;
        for (int i = 0; i < N + 1; i++) tick();
        check("R10 cpu gated while low", cpu_clk_en, 1'b0);
        check("R10 osc on while low", osc_en, 1'b1);
        tick(); tick(); tick();
        check("R10 still gated", cpu_clk_en, 1'b0);
        ext_pin_n = 2'b11;
        tick();
        check("R10 cpu open", cpu_clk_en, 1'b1);
        check("R10 pdown_flag cleared", pdown_flag, 1'b0);
        check("R10 no restore strobe", sfr_init, 1'b0);
        ext_en = 2'b00;

        // R11 reset exits power-down
        write_mode(1'b0, 1'b1);
        rst_n = 1'b0;
        tick();
        check("R11 strobe on pd reset", sfr_init, 1'b1);
        rst_n = 1'b1;
        tick();
        check("R11 run after pd reset", cpu_clk_en, 1'b1);
        check("R11 pdown_flag cleared", pdown_flag, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule